// File: doc/BRIEF.md
# Debug Mailbox with Channel Interrupts

This block is a two-way, single-word mailbox between an external debugger and the processor it controls. One transfer register carries a word from the debugger to the processor (the receive direction). The other carries a word from the processor back to the debugger (the transmit direction). Each register has a full flag. Both flags and two sticky overrun bits can be read in a status word from either side.

Two level-sensitive lines are meant for an interrupt controller, so processor software can serve the channel without polling. `comm_rx_o` is high while a received word waits to be read. `comm_tx_o` is high while the transmit register can take a new word. Both lines are taken directly from the status flags.

Each side has a one-bit select. Select 0 addresses the data register and select 1 addresses the status word. Read data is combinational from the current state. A read clears a flag at the next clock edge.

Top module: `dbg_mailbox`

## Requirements
- R1: A debugger write with select 0 while the receive register is empty stores the word and sets the receive-full flag at the next edge. From that edge on, a processor read with select 0 returns the stored word.
- R2: `comm_rx_o` equals status bit 30 (receive full) in every cycle.
- R3: A processor read with select 0 while the receive register is full returns the held word in that cycle. It clears the receive-full flag at the next edge, so `comm_rx_o` falls.
- R4: A processor write with select 0 while the transmit register is empty stores the word and sets the transmit-full flag (status bit 29). A debugger read with select 0 while full returns that word and clears the flag at the next edge.
- R5: `comm_tx_o` equals the inverse of status bit 29 in every cycle.
- R6: A write into a register whose full flag is set is dropped and the held word is kept. The write sets a sticky overrun bit: bit 27 for the receive register, bit 26 for the transmit register. The bit stays set until reset.
- R7: A read with select 0 from an empty register returns the last word held and leaves the flag clear.
- R8: A write and a flag-clearing read to the same register in the same cycle are handled as follows. The reader gets the old word, the new word is stored, the flag stays set, and no overrun is recorded.
- R9: Reset clears both flags, both overrun bits and both data words. `comm_tx_o` is then 1 and `comm_rx_o` is 0.
- R10: The status word reads as {0, rx_full, tx_full, 0, rx_ovr, tx_ovr, 26 zeros} in bits 31..0. Any bits above 31 read as zero. A write to the status select is ignored, and a status read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_sel_i | input | 1 | Debugger select: 0 data, 1 status |
| dbg_we_i | input | 1 | Debugger write strobe |
| dbg_re_i | input | 1 | Debugger read strobe |
| dbg_wdata_i | input | DATA_W | Debugger write word |
| dbg_rdata_o | output | DATA_W | Debugger read word |
| cpu_sel_i | input | 1 | Processor select: 0 data, 1 status |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_re_i | input | 1 | Processor read strobe |
| cpu_wdata_i | input | DATA_W | Processor write word |
| cpu_rdata_o | output | DATA_W | Processor read word |
| comm_rx_o | output | 1 | Receive word waiting |
| comm_tx_o | output | 1 | Transmit register free |

## Verification
The hardest situation to bring about is a collision in which the register is already full and a write and a clearing read hit it in the same cycle. Both sides must act on the same edge with the correct select. The bench first fills each register, then drives both strobes together, and checks that the old word is returned, the new word is held and no overrun bit appears. A random phase then mixes strobes and selects on both sides at high density. A behavioural model is compared against both read ports and both interrupt lines every cycle.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int STAT_W      = 32;
  localparam int BIT_RX_FULL = 30;
  localparam int BIT_TX_FULL = 29;
  localparam int BIT_RX_OVR  = 27;
  localparam int BIT_TX_OVR  = 26;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_STAT = 1'b1
  } sel_e;

  typedef struct packed {
    logic rx_full;
    logic tx_full;
    logic rx_ovr;
    logic tx_ovr;
  } flags_t;
endpackage

// File: rtl/dbgmb_xfer_reg.sv
module dbgmb_xfer_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, ovr_q;
  logic              clr, accept;

  assign clr    = rd_i & full_q;
  // a clearing read in the same cycle frees the slot for the write
  assign accept = wr_i & (~full_q | rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= wdata_i;
        full_q <= 1'b1;
      end else if (clr) begin
        full_q <= 1'b0;
      end
      if (wr_i && !accept) ovr_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/dbgmb_status.sv
module dbgmb_status
  import dbgmb_pkg::*;
(
  input  flags_t            flags_i,
  output logic [STAT_W-1:0] stat_o
);
  always_comb begin
    stat_o              = '0;
    stat_o[BIT_RX_FULL] = flags_i.rx_full;
    stat_o[BIT_TX_FULL] = flags_i.tx_full;
    stat_o[BIT_RX_OVR]  = flags_i.rx_ovr;
    stat_o[BIT_TX_OVR]  = flags_i.tx_ovr;
  end
endmodule

// File: rtl/dbgmb_rd_mux.sv
module dbgmb_rd_mux
  import dbgmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_DATA) rdata_o = data_i;
    else                   rdata_o[STAT_W-1:0] = stat_i;
  end
endmodule

// File: rtl/dbg_mailbox.sv
// DATA_W must be at least dbgmb_pkg::STAT_W
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_sel_i,
  input  logic              dbg_we_i,
  input  logic              dbg_re_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  input  logic              cpu_sel_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              comm_rx_o,
  output logic              comm_tx_o
);
  logic [DATA_W-1:0] rx_data, tx_data;
  logic [STAT_W-1:0] stat_w;
  flags_t            flags;
  logic              rx_wr, rx_rd, tx_wr, tx_rd;

  assign rx_wr = dbg_we_i & (dbg_sel_i == SEL_DATA);
  assign rx_rd = cpu_re_i & (cpu_sel_i == SEL_DATA);
  assign tx_wr = cpu_we_i & (cpu_sel_i == SEL_DATA);
  assign tx_rd = dbg_re_i & (dbg_sel_i == SEL_DATA);

  dbgmb_xfer_reg #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .wr_i(rx_wr), .wdata_i(dbg_wdata_i), .rd_i(rx_rd),
    .data_o(rx_data), .full_o(flags.rx_full), .ovr_o(flags.rx_ovr)
  );

  dbgmb_xfer_reg #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i(tx_wr), .wdata_i(cpu_wdata_i), .rd_i(tx_rd),
    .data_o(tx_data), .full_o(flags.tx_full), .ovr_o(flags.tx_ovr)
  );

  dbgmb_status u_stat (.flags_i(flags), .stat_o(stat_w));

  dbgmb_rd_mux #(.DATA_W(DATA_W)) u_dbg_mux (
    .sel_i(sel_e'(dbg_sel_i)), .data_i(tx_data), .stat_i(stat_w), .rdata_o(dbg_rdata_o)
  );

  dbgmb_rd_mux #(.DATA_W(DATA_W)) u_cpu_mux (
    .sel_i(sel_e'(cpu_sel_i)), .data_i(rx_data), .stat_i(stat_w), .rdata_o(cpu_rdata_o)
  );

  // interrupt lines come straight from the status word
  assign comm_rx_o = stat_w[BIT_RX_FULL];
  assign comm_tx_o = ~stat_w[BIT_TX_FULL];
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dbg_sel_i,
  input logic dbg_we_i,
  input logic cpu_sel_i,
  input logic cpu_we_i,
  input logic cpu_re_i,
  input logic comm_rx_o,
  input logic comm_tx_o,
  input logic rx_full_i,
  input logic tx_full_i,
  input logic rx_ovr_i,
  input logic tx_ovr_i
);
  logic dbg_wd, cpu_rd, cpu_wd;
  assign dbg_wd = dbg_we_i & ~dbg_sel_i;
  assign cpu_rd = cpu_re_i & ~cpu_sel_i;
  assign cpu_wd = cpu_we_i & ~cpu_sel_i;

  assert_rx_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wd && !rx_full_i |=> rx_full_i);
  assert_rx_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comm_rx_o == rx_full_i);
  assert_rx_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd && rx_full_i && !dbg_wd |=> !comm_rx_o);
  assert_tx_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wd && !tx_full_i |=> !comm_tx_o);
  assert_tx_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comm_tx_o == !tx_full_i);
  assert_rx_ovr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wd && rx_full_i && !cpu_rd |=> rx_ovr_i);
  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_i || tx_ovr_i |=> $past(rx_ovr_i) <= rx_ovr_i && $past(tx_ovr_i) <= tx_ovr_i);
  assert_empty_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd && !rx_full_i && !dbg_wd |=> !rx_full_i);
  assert_collide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wd && cpu_rd && rx_full_i |=> rx_full_i && $stable(rx_ovr_i));
  assert_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> comm_tx_o && !comm_rx_o && !rx_ovr_i && !tx_ovr_i);
  assert_stat_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_we_i && dbg_sel_i && !rx_full_i |=> !rx_full_i);
endmodule

bind dbg_mailbox dbg_mailbox_chk u_chk (
  .clk_i, .rst_ni, .dbg_sel_i, .dbg_we_i, .cpu_sel_i, .cpu_we_i, .cpu_re_i,
  .comm_rx_o, .comm_tx_o,
  .rx_full_i(stat_w[30]), .tx_full_i(stat_w[29]),
  .rx_ovr_i(stat_w[27]), .tx_ovr_i(stat_w[26])
);

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic d_sel = 0, d_we = 0, d_re = 0, c_sel = 0, c_we = 0, c_re = 0;
  logic [DW-1:0] d_wd = '0, c_wd = '0, d_rd, c_rd;
  logic irq_rx, irq_tx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_rx = '0, m_tx = '0;
  bit m_rxf = 0, m_txf = 0, m_rxo = 0, m_txo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_mailbox #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dbg_sel_i(d_sel), .dbg_we_i(d_we), .dbg_re_i(d_re), .dbg_wdata_i(d_wd), .dbg_rdata_o(d_rd),
    .cpu_sel_i(c_sel), .cpu_we_i(c_we), .cpu_re_i(c_re), .cpu_wdata_i(c_wd), .cpu_rdata_o(c_rd),
    .comm_rx_o(irq_rx), .comm_tx_o(irq_tx)
  );

  function automatic logic [DW-1:0] m_stat();
    logic [DW-1:0] s = '0;
    s[30] = m_rxf; s[29] = m_txf; s[27] = m_rxo; s[26] = m_txo;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, then advance one edge
  task automatic cyc(input string tag);
    logic [DW-1:0] ed, ec;
    bit rxw, rxr, txw, txr;
    #1;
    ed = d_sel ? m_stat() : m_tx;
    ec = c_sel ? m_stat() : m_rx;
    check(d_rd == ed, {tag, " dbg_rdata"}, d_rd, ed);
    check(c_rd == ec, {tag, " cpu_rdata"}, c_rd, ec);
    check(irq_rx == m_rxf, {tag, " R2 comm_rx"}, DW'(irq_rx), DW'(m_rxf));
    check(irq_tx == !m_txf, {tag, " R5 comm_tx"}, DW'(irq_tx), DW'(!m_txf));
    rxw = d_we && !d_sel; rxr = c_re && !c_sel && m_rxf;
    txw = c_we && !c_sel; txr = d_re && !d_sel && m_txf;
    @(posedge clk);
    if (rxw && (!m_rxf || rxr)) begin m_rx = d_wd; m_rxf = 1; end
    else if (rxw) m_rxo = 1;
    else if (rxr) m_rxf = 0;
    if (txw && (!m_txf || txr)) begin m_tx = c_wd; m_txf = 1; end
    else if (txw) m_txo = 1;
    else if (txr) m_txf = 0;
    @(negedge clk);
    {d_we, d_re, c_we, c_re, d_sel, c_sel} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check(irq_tx == 1 && irq_rx == 0, "R9 reset irqs", {irq_rx, irq_tx}, 2'b01);
    check(c_rd == '0, "R9 reset data", c_rd, '0);
    rst_n = 1;
    @(negedge clk);
    // R1 fill receive, R3 drain
    d_we = 1; d_wd = 32'hA5A5_0001; cyc("R1 write");
    c_sel = 1; cyc("R10 status read");
    c_re = 1; cyc("R3 read");
    cyc("R3 after read");
    c_re = 1; cyc("R7 empty read rx");
    d_re = 1; cyc("R7 empty read tx");
    // R4 transmit path
    c_we = 1; c_wd = 32'h0BAD_F00D; cyc("R4 write");
    d_sel = 1; cyc("R10 status tx");
    d_re = 1; cyc("R4 read");
    // R10 status write ignored
    d_we = 1; d_sel = 1; d_wd = 32'hFFFF_FFFF; cyc("R10 stat write");
    c_we = 1; c_sel = 1; c_wd = 32'hFFFF_FFFF; cyc("R10 stat write cpu");
    // R8 collision on both registers
    d_we = 1; d_wd = 32'h1111_1111; c_we = 1; c_wd = 32'h2222_2222; cyc("R8 fill");
    d_we = 1; d_wd = 32'h3333_3333; c_re = 1; cyc("R8 rx collide");
    c_we = 1; c_wd = 32'h4444_4444; d_re = 1; cyc("R8 tx collide");
    c_sel = 1; cyc("R8 no overrun");
    // R6 overruns
    d_we = 1; d_wd = 32'h5555_5555; cyc("R6 rx drop");
    c_we = 1; c_wd = 32'h6666_6666; cyc("R6 tx drop");
    d_sel = 1; cyc("R6 status");
    c_re = 1; cyc("R6 kept word");
    d_re = 1; cyc("R6 kept tx word");
    c_sel = 1; cyc("R6 sticky");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      {d_sel, d_we, d_re, c_sel, c_we, c_re} = 6'($urandom);
      d_sel = d_sel & ($urandom_range(3) == 0);
      c_sel = c_sel & ($urandom_range(3) == 0);
      d_wd = $urandom; c_wd = $urandom;
      cyc("R1 R4 random");
    end
    // R9 reset mid-run
    rst_n = 0; #1;
    check(irq_tx == 1 && irq_rx == 0, "R9 async reset", {irq_rx, irq_tx}, 2'b01);
    m_rx = '0; m_tx = '0; m_rxf = 0; m_txf = 0; m_rxo = 0; m_txo = 0;
    @(negedge clk); rst_n = 1; @(negedge clk);
    c_sel = 1; cyc("R9 status after reset");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule